// File: doc/BRIEF.md
# Programmable Logic Cell with Lookup Table and Control-Rich Register

This block is a behavioural model of one programmable logic cell. A truth table held in a 16-bit configuration word forms a 4-input lookup table. A single-bit register follows the table. The register has a clock enable, synchronous clear and load, and asynchronous clear, preset and load. Configuration is applied through plain input ports and is treated as static. One mode bit selects normal or arithmetic operation. A second bit selects whether the routed output shows the table result or the register.

Neighbouring cells can be joined through two dedicated links. The table-chain link hands one cell's table result to the next cell's table without general routing. The register-chain link hands one cell's register value straight to the next cell's register. A string of cells can then shift data while each table computes something unrelated. The carry logic that arithmetic mode would feed is a separate block and is not modelled here.

Top module: `logic_cell`

## Requirements
- R1: In normal mode with the chain select off, the table result equals bit `cfg_truth[{din[3],din[2],din[1],din[0]}]`. With `cfg_bypass`=1, `route_out` shows it in the same cycle.
- R2: In arithmetic mode (`cfg_arith`=1), index bit 0 is `din[0] XOR addsub`. The upper three index bits come from `din[3:1]`.
- R3: In normal mode with `cfg_chain_sel`=1, `lut_chain_in` replaces `din[0]` as index bit 0, and `lut_chain_out` equals the table result. In arithmetic mode, `lut_chain_out` is 0 and `lut_chain_in` has no effect.
- R4: While `ena`=1 and no other control is active, a rising edge loads the register. It takes the table result when `cfg_reg_src`=0, and `reg_chain_in` when `cfg_reg_src`=1. With `cfg_bypass`=0, `route_out` shows the register and `local_out` shows the table result; `cfg_bypass`=1 swaps the two. `reg_chain_out` always shows the register.
- R5: While `ena`=0 and no asynchronous control is active, the register holds its value, even when `sync_clr` or `sync_load` is high.
- R6: While `ena`=1, `sync_clr` clears the register at the edge and takes priority over `sync_load`. `sync_load` loads `load_data` and takes priority over normal capture.
- R7: `async_clr` forces the register output to 0 at once, without a clock edge. The value stays 0 after release, and `async_clr` takes priority over every other control.
- R8: `async_pre` forces the register output to 1 at once and keeps it after release. It takes priority over `async_load` and over all synchronous controls.
- R9: `async_load` forces the register output to `load_data` at once and keeps that value after release. It takes priority over all synchronous controls and ignores `ena`.
- R10: When `rst_n` is low at a rising edge, the register clears. Once every asynchronous control is low, the output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register |
| cfg_truth | input | 16 | Truth table of the 4-input lookup table |
| cfg_arith | input | 1 | 1 = arithmetic mode, 0 = normal mode |
| cfg_chain_sel | input | 1 | Normal mode only: take index bit 0 from `lut_chain_in` |
| cfg_reg_src | input | 1 | Register data source: 0 = table result, 1 = `reg_chain_in` |
| cfg_bypass | input | 1 | 1 = `route_out` is combinational, 0 = registered |
| din | input | 4 | Data inputs; `din[0]` is index bit 0 |
| addsub | input | 1 | Dynamic add/subtract control, XORed into bit 0 in arithmetic mode |
| lut_chain_in | input | 1 | Table result from the previous cell |
| reg_chain_in | input | 1 | Register value from the previous cell |
| ena | input | 1 | Clock enable for all synchronous actions |
| sync_clr | input | 1 | Synchronous clear |
| sync_load | input | 1 | Synchronous load of `load_data` |
| async_clr | input | 1 | Asynchronous clear |
| async_pre | input | 1 | Asynchronous preset to 1 |
| async_load | input | 1 | Asynchronous load of `load_data` |
| load_data | input | 1 | Data for both load controls |
| route_out | output | 1 | Routed output, picked by `cfg_bypass` |
| local_out | output | 1 | Local output, the value `route_out` does not carry |
| lut_chain_out | output | 1 | Table result for the next cell; 0 in arithmetic mode |
| reg_chain_out | output | 1 | Register value for the next cell |

## Verification
The register is the cell's only state. A wrong value in it shows on `reg_chain_out` at once, and on `route_out` whenever bypass is off, so every register fault can be observed one cycle after the edge that caused it. A wrongly ordered asynchronous priority shows within the same cycle, before any edge. A wrong override that fails to persist shows at the first sample after the control is released. Table faults are purely combinational and show in the cycle the index is applied, so sweeping every index under several truth words and every mode exposes them directly.

// File: rtl/lcell_pkg.sv
// Package: shared sizes and the register control bundle of the logic cell.
// Assumes a power-of-two table size derived from the input count.
package lcell_pkg;
    localparam int LUT_INPUTS_DEF = 4;

    // Register control bundle carried from the top to the register module.
    typedef struct packed {
        logic ena;
        logic sclr;
        logic sload;
        logic aclr;
        logic apre;
        logic aload;
    } reg_ctrl_t;
endpackage

// File: rtl/lcell_lut.sv
// Module: lookup table with index-bit-0 steering.
// Picks the index bit 0 source (data, chain input, or data XOR add/sub)
// and reads the truth word. Assumes the configuration inputs are static.
module lcell_lut #(
    parameter int N_IN = 4,
    localparam int TBL = 1 << N_IN
) (
    input  logic [TBL-1:0]  truth,
    input  logic [N_IN-1:0] din,
    input  logic            cfg_arith,
    input  logic            cfg_chain_sel,
    input  logic            addsub,
    input  logic            chain_in,
    output logic            lut_out,
    output logic            chain_out
);
    logic            bit0;
    logic [N_IN-1:0] idx;

    // Select the source of index bit 0 according to the mode.
    always_comb begin
        if (cfg_arith)
            bit0 = din[0] ^ addsub;
        else if (cfg_chain_sel)
            bit0 = chain_in;
        else
            bit0 = din[0];
    end

    // Form the index and read the table; the chain output is held low in arithmetic mode.
    always_comb begin
        idx       = {din[N_IN-1:1], bit0};
        lut_out   = truth[idx];
        chain_out = cfg_arith ? 1'b0 : lut_out;
    end
endmodule

// File: rtl/lcell_reg.sv
// Module: cell register with enable, synchronous clear and load, and
// asynchronous clear, preset and load.
// Asynchronous controls act on the output at once and are captured at the
// next edge, so the forced value persists after release.
// Priority: aclr > apre > aload > (ena: sclr > sload > data).
module lcell_reg
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  reg_ctrl_t ctrl,
    input  logic      adata,
    input  logic      d,
    output logic      q_out
);
    logic q;

    // Capture state at the edge in the priority order of the controls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (ctrl.aclr)
            q <= 1'b0;
        else if (ctrl.apre)
            q <= 1'b1;
        else if (ctrl.aload)
            q <= adata;
        else if (ctrl.ena) begin
            if (ctrl.sclr)
                q <= 1'b0;
            else if (ctrl.sload)
                q <= adata;
            else
                q <= d;
        end
    end

    // Apply the asynchronous overrides to the visible output without waiting for a clock.
    always_comb begin
        if (ctrl.aclr)
            q_out = 1'b0;
        else if (ctrl.apre)
            q_out = 1'b1;
        else if (ctrl.aload)
            q_out = adata;
        else
            q_out = q;
    end

    p_aclr_persist_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.aclr |=> (ctrl.apre || ctrl.aload || !q_out));

    p_apre_persist_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.apre && !ctrl.aclr) |=> (ctrl.aclr || ctrl.aload || q_out));

    p_sclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ena && ctrl.sclr && !ctrl.aclr && !ctrl.apre && !ctrl.aload)
        |=> (ctrl.apre || ctrl.aload || !q_out));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.ena && !ctrl.aclr && !ctrl.apre && !ctrl.aload)
        |=> (ctrl.aclr || ctrl.apre || ctrl.aload || (q_out == $past(q_out))));
endmodule

// File: rtl/logic_cell.sv
// Module: top of the programmable logic cell.
// Joins the lookup table and the register, picks the register source,
// and steers the routed and local outputs. Assumes static configuration.
module logic_cell
    import lcell_pkg::*;
#(
    parameter int LUT_INPUTS = LUT_INPUTS_DEF,
    localparam int LUT_SIZE = 1 << LUT_INPUTS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LUT_SIZE-1:0]   cfg_truth,
    input  logic                  cfg_arith,
    input  logic                  cfg_chain_sel,
    input  logic                  cfg_reg_src,
    input  logic                  cfg_bypass,
    input  logic [LUT_INPUTS-1:0] din,
    input  logic                  addsub,
    input  logic                  lut_chain_in,
    input  logic                  reg_chain_in,
    input  logic                  ena,
    input  logic                  sync_clr,
    input  logic                  sync_load,
    input  logic                  async_clr,
    input  logic                  async_pre,
    input  logic                  async_load,
    input  logic                  load_data,
    output logic                  route_out,
    output logic                  local_out,
    output logic                  lut_chain_out,
    output logic                  reg_chain_out
);
    logic      lut_res;
    logic      reg_d;
    logic      reg_q;
    reg_ctrl_t ctrl;

    lcell_lut #(.N_IN(LUT_INPUTS)) i_lut (
        .truth         (cfg_truth),
        .din           (din),
        .cfg_arith     (cfg_arith),
        .cfg_chain_sel (cfg_chain_sel),
        .addsub        (addsub),
        .chain_in      (lut_chain_in),
        .lut_out       (lut_res),
        .chain_out     (lut_chain_out)
    );

    // Bundle the register controls and pick the register data source for packing.
    always_comb begin
        ctrl  = '{ena: ena, sclr: sync_clr, sload: sync_load,
                  aclr: async_clr, apre: async_pre, aload: async_load};
        reg_d = cfg_reg_src ? reg_chain_in : lut_res;
    end

    lcell_reg i_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl),
        .adata (load_data),
        .d     (reg_d),
        .q_out (reg_q)
    );

    // Steer the outputs: route_out follows bypass and local_out carries the other value.
    always_comb begin
        route_out     = cfg_bypass ? lut_res : reg_q;
        local_out     = cfg_bypass ? reg_q : lut_res;
        reg_chain_out = reg_q;
    end

    p_chain_matches_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_arith && cfg_bypass) |-> (lut_chain_out == route_out));

    p_regchain_vs_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bypass |-> (reg_chain_out == route_out));
endmodule

// File: tb/test_logic_cell.sv
// Bench: sweeps every table index under several truth words and modes,
// then every combination of the register controls against a bench model.
module test_logic_cell;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_truth;
    logic        cfg_arith, cfg_chain_sel, cfg_reg_src, cfg_bypass;
    logic [3:0]  din;
    logic        addsub, lut_chain_in, reg_chain_in;
    logic        ena, sync_clr, sync_load, async_clr, async_pre, async_load, load_data;
    logic        route_out, local_out, lut_chain_out, reg_chain_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    logic_cell i_logic_cell (
        .clk(clk), .rst_n(rst_n), .cfg_truth(cfg_truth), .cfg_arith(cfg_arith),
        .cfg_chain_sel(cfg_chain_sel), .cfg_reg_src(cfg_reg_src), .cfg_bypass(cfg_bypass),
        .din(din), .addsub(addsub), .lut_chain_in(lut_chain_in), .reg_chain_in(reg_chain_in),
        .ena(ena), .sync_clr(sync_clr), .sync_load(sync_load), .async_clr(async_clr),
        .async_pre(async_pre), .async_load(async_load), .load_data(load_data),
        .route_out(route_out), .local_out(local_out), .lut_chain_out(lut_chain_out),
        .reg_chain_out(reg_chain_out)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input int k);
        case (k)
            0: return 16'hA5C3;
            1: return 16'h8001;
            2: return 16'h6996;
            default: return 16'h3E7B;
        endcase
    endfunction

    task automatic clear_ctrl();
        ena = 0; sync_clr = 0; sync_load = 0;
        async_clr = 0; async_pre = 0; async_load = 0; load_data = 0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic q_m;
        logic nq;
        logic lutv;
        logic [3:0] ix;
        rst_n = 0; cfg_truth = 16'h0; cfg_arith = 0; cfg_chain_sel = 0;
        cfg_reg_src = 0; cfg_bypass = 0; din = 0; addsub = 0;
        lut_chain_in = 0; reg_chain_in = 0;
        clear_ctrl();
        repeat (2) @(negedge clk);
        chk(route_out, 1'b0, "R10 reset route_out");
        chk(reg_chain_out, 1'b0, "R10 reset reg_chain_out");
        rst_n = 1;

        // R1 normal mode sweep, combinational output
        cfg_bypass = 1;
        for (int k = 0; k < 4; k++) begin
            cfg_truth = word(k);
            for (int i = 0; i < 16; i++) begin
                din = 4'(i);
                #1;
                chk(route_out, cfg_truth[i], "R1 table read");
                chk(lut_chain_out, cfg_truth[i], "R3 chain out normal");
            end
        end

        // R2 arithmetic mode; R3 chain input ignored and chain out low
        cfg_arith = 1;
        cfg_chain_sel = 1;
        for (int k = 0; k < 4; k++) begin
            cfg_truth = word(k);
            for (int i = 0; i < 64; i++) begin
                din = 4'(i);
                addsub = i[4];
                lut_chain_in = i[5];
                ix = {din[3:1], din[0] ^ addsub};
                #1;
                chk(route_out, cfg_truth[ix], "R2 add/sub xor");
                chk(lut_chain_out, 1'b0, "R3 chain out low in arith");
            end
        end

        // R3 chain input replaces din[0] in normal mode
        cfg_arith = 0;
        addsub = 0;
        for (int k = 0; k < 4; k++) begin
            cfg_truth = word(k);
            for (int i = 0; i < 32; i++) begin
                din = 4'(i);
                lut_chain_in = i[4];
                ix = {din[3:1], lut_chain_in};
                #1;
                chk(route_out, cfg_truth[ix], "R3 chain in");
                chk(lut_chain_out, cfg_truth[ix], "R3 chain out");
            end
        end
        cfg_chain_sel = 0;

        // R4 registered capture from table or register chain
        cfg_bypass = 0;
        cfg_truth = word(2);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            din = 4'(i);
            cfg_reg_src = i[4];
            reg_chain_in = i[5];
            ena = 1;
            lutv = cfg_truth[din];
            nq = cfg_reg_src ? reg_chain_in : lutv;
            @(negedge clk);
            #1;
            chk(route_out, nq, "R4 captured value");
            chk(local_out, lutv, "R4 local shows table");
            chk(reg_chain_out, nq, "R4 reg chain out");
            cfg_bypass = 1;
            #1;
            chk(route_out, lutv, "R4 bypass swaps route");
            chk(local_out, nq, "R4 bypass swaps local");
            cfg_bypass = 0;
        end
        clear_ctrl();

        // Control sweep: R5..R9 with register fed from reg_chain_in
        cfg_truth = 16'h0;
        cfg_reg_src = 1;
        @(negedge clk);
        #1;
        q_m = route_out;
        for (int i = 0; i < 256; i++) begin
            string tg;
            logic imm;
            @(negedge clk);
            ena = i[0]; sync_clr = i[1]; sync_load = i[2];
            async_clr = i[3]; async_pre = i[4]; async_load = i[5];
            load_data = i[6]; reg_chain_in = i[7];
            if (async_clr) begin tg = "R7"; imm = 0; end
            else if (async_pre) begin tg = "R8"; imm = 1; end
            else if (async_load) begin tg = "R9"; imm = load_data; end
            else begin tg = (!ena) ? "R5" : ((sync_clr || sync_load) ? "R6" : "R4"); imm = q_m; end
            #1;
            chk(route_out, imm, {tg, " immediate"});
            if (async_clr || async_pre || async_load) q_m = imm;
            else if (ena) q_m = sync_clr ? 1'b0 : (sync_load ? load_data : reg_chain_in);
            @(negedge clk);
            clear_ctrl();
            #1;
            chk(route_out, q_m, {tg, " after edge and release"});
        end

        // R10 synchronous reset clears a set register
        @(negedge clk);
        async_pre = 1;
        @(negedge clk);
        async_pre = 0;
        #1;
        chk(route_out, 1'b1, "R8 preset persists before reset");
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(route_out, 1'b0, "R10 reset clears register");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule